// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external 8K x 8 asynchronous static RAM. The host posts a single read or write request. The controller then produces the strobe sequence the RAM needs and holds each phase for a whole number of clock cycles. Every phase length is derived from a clock-period parameter and a speed-grade parameter: the nanosecond limit is divided by the clock period and rounded up. The RAM is selected by a pair of chip enables of opposite polarity, written with an active-low write strobe and read with an active-low output enable. Its bidirectional data bus is carried as three separate signals: driven value, sampled value and drive enable.

A write opens the chip with the output enable held high. It waits for the RAM outputs to float. It then drives the bus and pulses the write strobe, and it keeps the data and address one phase beyond the strobe's rising edge. A read holds the write strobe high, opens the chip with the output enable low, waits out the access time and captures the bus on a clock edge. Either kind of access ends with the chip deselected and a single-cycle completion pulse. A request that arrives while an access is in progress is dropped.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and right after reset, the chip is deselected (`mem_cs_n`=1, `mem_cs`=0), `mem_we_n`=1, `mem_oe_n`=1, `dq_oe`=0, `busy`=0, `done`=0 and `rd_data`=0.
- R2: The two chip enables always move together. The chip is selected (`mem_cs_n`=0 and `mem_cs`=1) in exactly those cycles in which `busy` is 1.
- R3: In a write, the chip is selected with `mem_oe_n`=1, `mem_we_n`=1 and `dq_oe`=0 for ceil(20 ns / period) cycles before the write strobe falls. This is 1 cycle at the defaults. `mem_we_n` is low only while the chip is selected and `mem_oe_n` is high.
- R4: Each write gives one low pulse on `mem_we_n`. The pulse lasts max(ceil(60/P), ceil(40/P), ceil(tAW/P) minus the R3 count) cycles, where P is the period in ns and tAW is 70 ns on the fast grade or 80 ns on the slow grade. This is 3 cycles at the defaults (P=20, fast). The RAM then holds the posted byte at the posted address.
- R5: `dq_oe` rises together with the falling edge of `mem_we_n` and stays high for max(1, ceil(tWC/P) minus the R3 count minus the R4 count) cycles after `mem_we_n` rises. tWC is 80 ns on the fast grade or 100 ns on the slow grade. This gives 1 cycle and a 5-cycle write at the defaults. The address and write data stay constant while the chip is selected.
- R6: `mem_oe_n` stays high for the whole of a write. `dq_oe` is never 1 while `mem_oe_n` is 0, or within 20 ns after the RAM outputs were last enabled.
- R7: A read holds `mem_we_n`=1 and `dq_oe`=0 and selects the chip with `mem_oe_n`=0 for max(ceil(tAA/P), ceil(40/P)) cycles. tAA is 80 ns on the fast grade or 100 ns on the slow grade, giving 4 cycles at the defaults. `rd_data` takes `dq_in` on the clock edge that ends this window and holds it until the next read completes.
- R8: `busy` is 1 from the cycle after a request is accepted until the access ends. `done` is 1 for exactly the single cycle after that. A request is accepted on any clock edge where `busy` is 0 and `req` is 1, including the `done` cycle.
- R9: A request presented while `busy` is 1 is ignored. It produces no access, and no address or data change on the memory side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, sampled on rising edges while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Data captured by the most recent read |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 13 | Address to the RAM |
| mem_cs_n | output | 1 | Active-low chip enable |
| mem_cs | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| dq_out | output | 8 | Value the controller drives onto the data bus |
| dq_in | input | 8 | Value sampled from the data bus |
| dq_oe | output | 1 | Controller drives the data bus when 1 |

## Verification
The bench's memory model returns a wrong pattern until the access time has elapsed. A controller that captures read data one edge early therefore returns that pattern instead of the stored byte. The model flags a bus drive that overlaps enabled RAM outputs, or that follows them too closely. This catches a design that skips the float wait, or that lets a write chase a read without it. It measures each write strobe and the data setup before the strobe's rising edge, and it checks that the data is still driven at that edge. A short pulse, or data released together with the strobe, shows up as a bad or missing stored byte. Back-to-back requests issued in the completion cycle, and requests held high during an access, expose a controller that accepts at the wrong time or lets a second request overwrite the latched address.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPUL,
        ST_WHLD,
        ST_RACC
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       ce_on;
        logic       we_on;
        logic       oe_on;
        logic       drv;
        logic       done;
    } ctl_s;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_load,
    input  logic          rd_cap,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic [DW-1:0] rd;
    } dp_s;

    dp_s dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (cmd_load) begin
            dp_d.addr = req_addr;
            dp_d.wd   = req_wdata;
        end
        if (rd_cap)
            dp_d.rd = dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign mem_addr = dp_q.addr;
    assign dq_out   = dp_q.wd;
    assign rd_data  = dp_q.rd;

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int CW      = 4,
    parameter int HZ_CYC  = 1,
    parameter int WP_CYC  = 3,
    parameter int HLD_CYC = 1,
    parameter int ACC_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          cmd_load,
    output logic          rd_cap,
    output ctl_s          ctl
);
    localparam logic [CW-1:0] HZ_L  = CW'(HZ_CYC - 1);
    localparam logic [CW-1:0] WP_L  = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] HLD_L = CW'(HLD_CYC - 1);
    localparam logic [CW-1:0] ACC_L = CW'(ACC_CYC - 1);

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        cmd_load   = 1'b0;
        rd_cap     = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req) begin
                    cmd_load    = 1'b1;
                    tmr_load    = 1'b1;
                    ctl_d.ce_on = 1'b1;
                    if (req_wr) begin
                        ctl_d.st = ST_WSET;
                        tmr_val  = HZ_L;
                    end else begin
                        ctl_d.st    = ST_RACC;
                        ctl_d.oe_on = 1'b1;
                        tmr_val     = ACC_L;
                    end
                end
            end
            ST_WSET: begin
                if (tmr_zero) begin
                    ctl_d.st    = ST_WPUL;
                    ctl_d.we_on = 1'b1;
                    ctl_d.drv   = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = WP_L;
                end
            end
            ST_WPUL: begin
                if (tmr_zero) begin
                    ctl_d.st    = ST_WHLD;
                    ctl_d.we_on = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = HLD_L;
                end
            end
            ST_WHLD: begin
                if (tmr_zero) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.ce_on = 1'b0;
                    ctl_d.drv   = 1'b0;
                    ctl_d.done  = 1'b1;
                end
            end
            ST_RACC: begin
                if (tmr_zero) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.ce_on = 1'b0;
                    ctl_d.oe_on = 1'b0;
                    ctl_d.done  = 1'b1;
                    rd_cap      = 1'b1;
                end
            end
            default: ctl_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    // Length of the current write-strobe pulse, kept for the width check
    logic [CW-1:0] we_lo_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           we_lo_q <= '0;
        else if (ctl_q.we_on) we_lo_q <= we_lo_q + 1'b1;
        else                  we_lo_q <= '0;
    end

    // R4
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.we_on) |-> (we_lo_q == CW'(WP_CYC)));

    // R3
    we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.we_on |-> (ctl_q.ce_on && !ctl_q.oe_on && ctl_q.drv));

    // R6
    no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.drv |-> !ctl_q.oe_on);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |=> !ctl_q.done);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int AW         = 13,
    parameter int DW         = 8,
    parameter int CLK_NS     = 20,
    parameter bit FAST_GRADE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] dq_out,
    input  logic [DW-1:0] dq_in,
    output logic          dq_oe
);
    localparam int T_WC_NS  = FAST_GRADE ? 80 : 100;
    localparam int T_AW_NS  = FAST_GRADE ? 70 : 80;
    localparam int T_AA_NS  = FAST_GRADE ? 80 : 100;
    localparam int T_WP_NS  = 60;
    localparam int T_DW_NS  = 40;
    localparam int T_OE_NS  = 40;
    localparam int T_OHZ_NS = 20;

    localparam int HZ_CYC  = imax(1, ns_to_cyc(T_OHZ_NS, CLK_NS));
    localparam int WP_CYC  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                  imax(1, ns_to_cyc(T_AW_NS, CLK_NS) - HZ_CYC));
    localparam int HLD_CYC = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - HZ_CYC - WP_CYC);
    localparam int ACC_CYC = imax(1, imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
    localparam int MAX_CYC = imax(imax(HZ_CYC, WP_CYC), imax(HLD_CYC, ACC_CYC));
    localparam int CW      = $clog2(MAX_CYC + 1) + 1;

    logic          tmr_zero, tmr_load, cmd_load, rd_cap;
    logic [CW-1:0] tmr_val;
    ctl_s          ctl;

    sram_seq_fsm #(
        .CW(CW), .HZ_CYC(HZ_CYC), .WP_CYC(WP_CYC),
        .HLD_CYC(HLD_CYC), .ACC_CYC(ACC_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .cmd_load(cmd_load), .rd_cap(rd_cap), .ctl(ctl)
    );

    sram_seq_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_zero)
    );

    sram_seq_dpath #(.AW(AW), .DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .rd_cap(rd_cap),
        .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(dq_in),
        .mem_addr(mem_addr), .dq_out(dq_out), .rd_data(rd_data)
    );

    assign busy     = (ctl.st != ST_IDLE);
    assign done     = ctl.done;
    assign mem_cs_n = ~ctl.ce_on;
    assign mem_cs   = ctl.ce_on;
    assign mem_we_n = ~ctl.we_on;
    assign mem_oe_n = ~ctl.oe_on;
    assign dq_oe    = ctl.drv;

    // R2
    cs_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && mem_cs) == busy);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> dq_oe);

    // R9
    addr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mem_addr) && $stable(dq_out));

    // R7
    read_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !dq_oe && !mem_cs_n));

endmodule

// File: tb/sim_sram_seq_ctrl.sv
module sim_sram_seq_ctrl;
    localparam int CLK_NS = 20;
    localparam int T_AA   = 80;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Phase lengths from the requirements at the default fast grade
    localparam int HZ  = cdiv(20, CLK_NS);
    localparam int WP  = 3;
    localparam int HD  = 1;
    localparam int AC  = cdiv(T_AA, CLK_NS);
    localparam int N_W = HZ + WP + HD;
    localparam int N_R = AC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data, dq_out, dq_in;
    logic        busy, done, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, dq_oe;
    logic [12:0] mem_addr;

    always #(CLK_NS/2) clk = ~clk;

    sram_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .dq_out(dq_out), .dq_in(dq_in), .dq_oe(dq_oe)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] bg(input logic [12:0] a);
        return a[7:0] ^ 8'h5A ^ {3'b000, a[12:8]};
    endfunction

    // Reference model and the RAM contents the host expects
    logic [7:0] ram_exp [int];
    logic [7:0] ram_act [int];
    int         ph = 0;
    bit         op_wr = 1'b0;
    logic [12:0] m_a = '0;
    logic [7:0]  m_d = '0;
    logic [7:0]  rd_e = '0;
    bit          done_e = 1'b0;

    function automatic logic [7:0] rd_exp_mem(input logic [12:0] a);
        return ram_exp.exists(int'(a)) ? ram_exp[int'(a)] : bg(a);
    endfunction

    function automatic logic [7:0] rd_act_mem(input logic [12:0] a);
        return ram_act.exists(int'(a)) ? ram_act[int'(a)] : bg(a);
    endfunction

    int rd_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; done_e = 1'b0; rd_e = '0; rd_cnt = 0;
        end else begin
            if (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n) rd_cnt = rd_cnt + 1;
            else rd_cnt = 0;
            done_e = 1'b0;
            if (ph == 0) begin
                if (req) begin
                    ph = 1; op_wr = req_wr; m_a = req_addr; m_d = req_wdata;
                end
            end else if (ph == (op_wr ? N_W : N_R)) begin
                ph = 0; done_e = 1'b1;
                if (op_wr) ram_exp[int'(m_a)] = m_d;
                else       rd_e = rd_exp_mem(m_a);
            end else begin
                ph = ph + 1;
            end
        end
    end

    // RAM model with timing monitors, and the per-cycle comparison
    int  cyc = 0;
    int  last_act = -1000;
    int  lo_cnt = 0;
    int  drv_cnt = 0;
    bit  prev_we = 1'b1;
    logic [7:0] dq_r = 8'hA5;
    assign dq_in = dq_r;

    always @(negedge clk) begin
        bit sel, out_act, e_we_n, e_oe_n, e_drv;
        cyc++;
        sel     = !mem_cs_n && mem_cs;
        out_act = sel && !mem_oe_n && mem_we_n;
        dq_r    = ((rd_cnt + 1) * CLK_NS >= T_AA) ? rd_act_mem(mem_addr) : 8'hA5;
        if (rst_n) begin
            if (dq_oe)
                chk(!out_act && (cyc - last_act) * CLK_NS >= 20,
                    "R6 bus contention", cyc - last_act, 1);
            if (out_act) last_act = cyc;
            if (!mem_we_n) begin
                lo_cnt++;
                chk(sel && mem_oe_n, "R3 strobe outside select", {sel, mem_oe_n}, 3);
            end
            drv_cnt = dq_oe ? drv_cnt + 1 : 0;
            if (mem_we_n && !prev_we) begin
                chk(lo_cnt * CLK_NS >= 60, "R4 strobe width", lo_cnt, WP);
                chk(dq_oe && (drv_cnt - 1) * CLK_NS >= 40, "R5 data setup/hold", drv_cnt, WP + 1);
                if (sel && dq_oe) ram_act[int'(mem_addr)] = dq_out;
                lo_cnt = 0;
            end
            prev_we = mem_we_n;

            e_we_n = !(op_wr && ph >= 1 + HZ && ph < 1 + HZ + WP);
            e_oe_n = !(ph != 0 && !op_wr);
            e_drv  = op_wr && ph >= 1 + HZ;
            chk(busy == (ph != 0), "R8 busy", busy, ph != 0);
            chk(done == done_e, "R8 done", done, done_e);
            chk(mem_cs_n == (ph == 0) && mem_cs == (ph != 0), "R2 chip enables",
                {mem_cs_n, mem_cs}, {ph == 0, ph != 0});
            chk(mem_we_n == e_we_n, "R4 write strobe", mem_we_n, e_we_n);
            chk(mem_oe_n == e_oe_n, op_wr ? "R6 output enable" : "R7 output enable",
                mem_oe_n, e_oe_n);
            chk(dq_oe == (ph != 0 && e_drv), "R3 bus drive", dq_oe, e_drv);
            if (ph != 0) chk(mem_addr == m_a, "R9 address", mem_addr, m_a);
            if (dq_oe)   chk(dq_out == m_d, "R5 write data", dq_out, m_d);
            chk(rd_data == rd_e, "R7 read data", rd_data, rd_e);
        end
    end

    task automatic do_req(input bit wr, input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        while (ph != 0) @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_idle();
        while (ph != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !dq_oe && !busy && !done
            && rd_data == 8'h00, "R1 reset outputs",
            {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, dq_oe, busy, done}, 7'b1011000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && !busy, "R1 after release", {mem_cs_n, busy}, 2'b10);

        // Basic write then read at the lowest and highest addresses
        do_req(1'b1, 13'h0000, 8'h3C); wait_idle();
        do_req(1'b0, 13'h0000, 8'h00); wait_idle();
        chk(rd_data == 8'h3C, "R7 read low address", rd_data, 8'h3C);
        do_req(1'b1, 13'h1FFF, 8'hC3); wait_idle();
        do_req(1'b0, 13'h1FFF, 8'h00); wait_idle();
        chk(rd_data == 8'hC3, "R7 read top address", rd_data, 8'hC3);

        // R9: request held during a write with another address and data
        do_req(1'b1, 13'h0100, 8'h11);
        req = 1'b1; req_wr = 1'b1; req_addr = 13'h0222; req_wdata = 8'hEE;
        repeat (3) @(negedge clk);
        req = 1'b0;
        wait_idle();
        chk(!ram_act.exists(32'h0222), "R9 ignored request wrote", 1, 0);
        do_req(1'b0, 13'h0222, 8'h00); wait_idle();
        chk(rd_data == bg(13'h0222), "R9 untouched location", rd_data, bg(13'h0222));

        // R8: back-to-back accesses accepted in the done cycle, read/write alternating
        for (int i = 0; i < 24; i++) begin
            logic [12:0] a;
            a = 13'((i * 13'd733 + 13'd91) & 13'h1FFF);
            do_req(1'b1, a, 8'((i * 37 + 5) & 8'hFF));
            do_req(1'b0, a, 8'h00);
        end
        wait_idle();

        // Read never-written locations directly after a write (R6 turnaround)
        for (int i = 0; i < 8; i++) begin
            do_req(1'b0, 13'(13'h1000 + i * 3), 8'h00);
            do_req(1'b1, 13'(13'h0800 + i), 8'(8'hF0 + i));
        end
        wait_idle();

        // Final memory image
        foreach (ram_exp[k])
            chk(ram_act.exists(k) && ram_act[k] == ram_exp[k], "R4 stored byte",
                ram_act.exists(k) ? int'(ram_act[k]) : -1, int'(ram_exp[k]));
        chk(ram_act.num() == ram_exp.num(), "R4 write count", ram_act.num(), ram_exp.num());
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule